// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block sequences a debug session through a short chain of states. Each comparator channel feeds it one of two kinds of qualified match. In forced mode, a raw address match on a fetch cycle passes through a short delay pipeline and then acts. In tagged mode, a tag hit reported by the execution stage acts on the next edge. A programmable table, with one entry per (current state, channel) pair, selects the state to move to.

Software drives the block with a single write strobe that carries an arm bit and a trigger bit. The trigger bit behaves according to the trace alignment setting. With begin alignment, it sends the session straight to Final, where tracing runs for a fixed number of cycles. With end alignment, it ends the session at once and raises a one-cycle breakpoint request. The block does not contain the comparators, the trace storage or the instruction queue.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset, `seq_state` is 0 (Disarmed), `status_flags` is all zero, and `trace_active` and `bkpt_req` are low.
- R2: A write with arm=1 and trigger=0 while Disarmed gives state 1 (State1) and clears all flags on the next edge. A write with arm=0 and trigger=0 gives state 0 on the next edge from any state.
- R3: A forced-mode channel whose `fetch_match` is sampled at edge k changes the state at edge k+2+FORCED_EXTRA, and not earlier. With the default FORCED_EXTRA=1 this is edge k+3.
- R4: In State1, State2 or State3 (codes 1, 2, 3), a qualified hit on channel i moves to the state coded in `cfg_next[((s-1)*NUM_CH+i)*2 +: 2]`. The codes are 0=State1, 1=State2, 2=State3, 3=Final (state code 4).
- R5: A channel with its `cfg_tag_mode` bit set reacts to `tag_hit` at the next edge and ignores `fetch_match`. A channel with the bit clear ignores `tag_hit`.
- R6: A hit sets the flag bit of the channel that caused it. When several channels hit on the same edge, only the lowest-numbered one acts and only its flag is set.
- R7: A write with trigger=1 while armed (or with arm=1) and begin alignment (`cfg_align_end`=0) gives state 4 on the next edge. It overrides any channel hit on that edge and sets no flag.
- R8: The same trigger with end alignment gives state 0 and raises `bkpt_req` for exactly one cycle.
- R9: A write with both arm and trigger set while Disarmed acts as an immediate trigger and clears the flags. A write with trigger alone while Disarmed has no effect.
- R10: When Final is entered with begin alignment, `trace_active` stays high for TRACE_DEPTH cycles, after which the state returns to 0.
- R11: When Final is entered through a hit with end alignment, `bkpt_req` is high and `trace_active` is low in that cycle, and the state is 0 on the next edge.
- R12: `trace_active` is high in states 1, 2 and 3.
- R13: Tag hits and forced matches have no effect while Disarmed or in Final.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Software write strobe for the control bits |
| cfg_arm | input | 1 | Arm bit carried by the write |
| cfg_trig | input | 1 | Trigger bit carried by the write |
| cfg_align_end | input | 1 | Trace alignment: 0 begin, 1 end |
| cfg_tag_mode | input | NUM_CH | Per channel: 1 tagged, 0 forced |
| cfg_next | input | 6*NUM_CH | Next-state codes, 2 bits per (state, channel) |
| fetch_match | input | NUM_CH | Raw comparator match on a fetch cycle |
| tag_hit | input | NUM_CH | Tag hit reported at execution |
| seq_state | output | 3 | Current state code |
| status_flags | output | NUM_CH | Sticky per-channel match flags |
| trace_active | output | 1 | Tracing is running |
| bkpt_req | output | 1 | One-cycle breakpoint request |

## Verification
Two kinds of event can land on the same edge. The first case pairs a delayed forced match with a direct tag hit on another channel. The bench issues the fetch match three cycles before the tag hit, so both reach the sequencer together. It then expects only the lower channel's target state and flag. The second case pairs a software trigger with a tag hit on the same edge. There the bench expects Final with the flags unchanged, which shows that the trigger wins and the hit leaves no trace.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

    localparam int CH_MAX = 8;

    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_S1    = 3'd1,
        SEQ_S2    = 3'd2,
        SEQ_S3    = 3'd3,
        SEQ_FINAL = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        NXT_S1    = 2'd0,
        NXT_S2    = 2'd1,
        NXT_S3    = 2'd2,
        NXT_FINAL = 2'd3
    } next_code_e;

    // Result of arbitration among channel hits.
    typedef struct packed {
        logic              valid;
        seq_state_e        target;
        logic [CH_MAX-1:0] chan_oh;
    } seq_hit_t;

    function automatic seq_state_e code_to_state(logic [1:0] code);
        case (next_code_e'(code))
            NXT_S1:  return SEQ_S1;
            NXT_S2:  return SEQ_S2;
            NXT_S3:  return SEQ_S3;
            default: return SEQ_FINAL;
        endcase
    endfunction

    function automatic logic in_match_state(seq_state_e s);
        return (s == SEQ_S1) || (s == SEQ_S2) || (s == SEQ_S3);
    endfunction

    // Row of the next-state table used by a state (0 for non-match states).
    function automatic int state_row(seq_state_e s);
        case (s)
            SEQ_S2:  return 1;
            SEQ_S3:  return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/dbgseq_fetch_pipe.sv
module dbgseq_fetch_pipe #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic match_in,
    output logic match_out
);
    logic [STAGES-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= match_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= {stage_q[STAGES-2:0], match_in};
            end
        end
    endgenerate

    assign match_out = stage_q[STAGES-1];
endmodule

// File: rtl/dbgseq_chan_qual.sv
module dbgseq_chan_qual #(
    parameter int FORCED_LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tag_mode,
    input  logic fetch_match,
    input  logic tag_hit,
    output logic hit
);
    logic forced_late;

    dbgseq_fetch_pipe #(.STAGES(FORCED_LAT)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .match_in  (fetch_match),
        .match_out (forced_late)
    );

    // Tagged channels listen to execution hits, forced ones to the delayed fetch match.
    assign hit = tag_mode ? tag_hit : forced_late;
endmodule

// File: rtl/dbgseq_arbiter.sv
module dbgseq_arbiter
    import dbgseq_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int TBL_W = 3 * NUM_CH * 2
) (
    input  seq_state_e        state,
    input  logic [NUM_CH-1:0] hits,
    input  logic [TBL_W-1:0]  cfg_next,
    output seq_hit_t          result
);
    always_comb begin
        int row;
        row            = state_row(state);
        result         = '0;
        result.target  = SEQ_IDLE;
        // Walk from the top so the lowest channel overwrites the others.
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (hits[i] && in_match_state(state)) begin
                result.valid      = 1'b1;
                result.chan_oh    = '0;
                result.chan_oh[i] = 1'b1;
                result.target     = code_to_state(cfg_next[(row * NUM_CH + i) * 2 +: 2]);
            end
        end
    end
endmodule

// File: rtl/dbgseq_fsm.sv
module dbgseq_fsm
    import dbgseq_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int TRACE_DEPTH = 8,
    localparam int CNT_W      = (TRACE_DEPTH > 2) ? $clog2(TRACE_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_arm,
    input  logic              cfg_trig,
    input  logic              cfg_align_end,
    input  seq_hit_t          hit,
    output seq_state_e        state,
    output logic [NUM_CH-1:0] flags,
    output logic              trace_active,
    output logic              bkpt_req
);
    seq_state_e        state_n;
    logic [NUM_CH-1:0] flags_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              bkpt_n;
    logic              armed;
    logic              trig_go;

    assign armed   = (state != SEQ_IDLE);
    assign trig_go = cfg_wr && cfg_trig && (cfg_arm || armed);

    always_comb begin
        state_n = state;
        flags_n = flags;
        cnt_n   = cnt_q;
        bkpt_n  = 1'b0;
        if (trig_go) begin
            if (!armed) flags_n = '0;
            cnt_n = '0;
            if (cfg_align_end) begin
                state_n = SEQ_IDLE;
                bkpt_n  = 1'b1;
            end else begin
                state_n = SEQ_FINAL;
            end
        end else if (cfg_wr && !cfg_arm) begin
            state_n = SEQ_IDLE;
        end else if (cfg_wr && cfg_arm && !armed) begin
            state_n = SEQ_S1;
            flags_n = '0;
        end else if (hit.valid) begin
            state_n = hit.target;
            flags_n = flags | hit.chan_oh[NUM_CH-1:0];
            if (hit.target == SEQ_FINAL) begin
                cnt_n  = '0;
                bkpt_n = cfg_align_end;
            end
        end else if (state == SEQ_FINAL) begin
            if (cfg_align_end || cnt_q == CNT_W'(TRACE_DEPTH - 1)) begin
                state_n = SEQ_IDLE;
            end else begin
                cnt_n = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            flags    <= '0;
            cnt_q    <= '0;
            bkpt_req <= 1'b0;
        end else begin
            state    <= state_n;
            flags    <= flags_n;
            cnt_q    <= cnt_n;
            bkpt_req <= bkpt_n;
        end
    end

    assign trace_active = in_match_state(state) ||
                          ((state == SEQ_FINAL) && !cfg_align_end);
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
    import dbgseq_pkg::*;
#(
    parameter int NUM_CH       = 2,
    parameter int FORCED_EXTRA = 1,
    parameter int TRACE_DEPTH  = 8,
    localparam int FORCED_LAT  = 2 + FORCED_EXTRA,
    localparam int TBL_W       = 3 * NUM_CH * 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_arm,
    input  logic              cfg_trig,
    input  logic              cfg_align_end,
    input  logic [NUM_CH-1:0] cfg_tag_mode,
    input  logic [TBL_W-1:0]  cfg_next,
    input  logic [NUM_CH-1:0] fetch_match,
    input  logic [NUM_CH-1:0] tag_hit,
    output logic [2:0]        seq_state,
    output logic [NUM_CH-1:0] status_flags,
    output logic              trace_active,
    output logic              bkpt_req
);
    logic [NUM_CH-1:0] chan_hit;
    seq_hit_t          arb_res;
    seq_state_e        cur_state;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
            dbgseq_chan_qual #(.FORCED_LAT(FORCED_LAT)) u_qual (
                .clk         (clk),
                .rst         (rst),
                .tag_mode    (cfg_tag_mode[g]),
                .fetch_match (fetch_match[g]),
                .tag_hit     (tag_hit[g]),
                .hit         (chan_hit[g])
            );
        end
    endgenerate

    dbgseq_arbiter #(.NUM_CH(NUM_CH)) u_arb (
        .state    (cur_state),
        .hits     (chan_hit),
        .cfg_next (cfg_next),
        .result   (arb_res)
    );

    dbgseq_fsm #(.NUM_CH(NUM_CH), .TRACE_DEPTH(TRACE_DEPTH)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cfg_wr        (cfg_wr),
        .cfg_arm       (cfg_arm),
        .cfg_trig      (cfg_trig),
        .cfg_align_end (cfg_align_end),
        .hit           (arb_res),
        .state         (cur_state),
        .flags         (status_flags),
        .trace_active  (trace_active),
        .bkpt_req      (bkpt_req)
    );

    assign seq_state = cur_state;
endmodule

// File: rtl/dbg_trig_seq_chk.sv
module dbg_trig_seq_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic              cfg_arm,
    input logic              cfg_trig,
    input logic              cfg_align_end,
    input logic [2:0]        seq_state,
    input logic [NUM_CH-1:0] status_flags,
    input logic              trace_active,
    input logic              bkpt_req
);
    assert_legal_state_R1: assert property (@(posedge clk) disable iff (rst)
        seq_state <= 3'd4);

    assert_arm_enters_s1_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_arm && !cfg_trig && seq_state == 3'd0)
        |=> (seq_state == 3'd1 && status_flags == '0));

    assert_disarm_write_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_arm && !cfg_trig) |=> (seq_state == 3'd0));

    assert_one_new_flag_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(status_flags & ~$past(status_flags)));

    assert_begin_trigger_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_trig && (cfg_arm || seq_state != 3'd0) && !cfg_align_end)
        |=> (seq_state == 3'd4));

    assert_end_trigger_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_trig && (cfg_arm || seq_state != 3'd0) && cfg_align_end)
        |=> (seq_state == 3'd0 && bkpt_req));

    assert_bkpt_single_R8: assert property (@(posedge clk) disable iff (rst)
        bkpt_req |=> !bkpt_req);

    assert_end_final_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 3'd4 && cfg_align_end) |-> !trace_active);

    assert_end_final_exits_R11: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 3'd4 && cfg_align_end && !cfg_wr) |=> (seq_state == 3'd0));

    assert_trace_in_match_R12: assert property (@(posedge clk) disable iff (rst)
        (seq_state >= 3'd1 && seq_state <= 3'd3) |-> trace_active);

    assert_idle_holds_R13: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 3'd0 && !(cfg_wr && cfg_arm)) |=> (seq_state == 3'd0));
endmodule

bind dbg_trig_seq dbg_trig_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_wr        (cfg_wr),
    .cfg_arm       (cfg_arm),
    .cfg_trig      (cfg_trig),
    .cfg_align_end (cfg_align_end),
    .seq_state     (seq_state),
    .status_flags  (status_flags),
    .trace_active  (trace_active),
    .bkpt_req      (bkpt_req)
);

// File: tb/sim_dbg_trig_seq.sv
`timescale 1ns/1ps
module sim_dbg_trig_seq;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_wr = 1'b0, cfg_arm = 1'b0, cfg_trig = 1'b0, cfg_align_end = 1'b0;
    logic [NCH-1:0] cfg_tag_mode = '0;
    logic [11:0]    cfg_next = 12'h3E9;
    logic [NCH-1:0] fetch_match = '0, tag_hit = '0;
    logic [2:0]     seq_state;
    logic [NCH-1:0] status_flags;
    logic           trace_active, bkpt_req;

    int cnt = 0;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        int         cyc;
        logic [2:0] st;
        logic [1:0] fl;
        logic       tr;
        logic       bk;
        string      req;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 1;

    dbg_trig_seq u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_arm(cfg_arm), .cfg_trig(cfg_trig),
        .cfg_align_end(cfg_align_end), .cfg_tag_mode(cfg_tag_mode), .cfg_next(cfg_next),
        .fetch_match(fetch_match), .tag_hit(tag_hit), .seq_state(seq_state),
        .status_flags(status_flags), .trace_active(trace_active), .bkpt_req(bkpt_req)
    );

    task automatic expa(int cyc, logic [2:0] st, logic [1:0] fl, logic tr, logic bk, string req);
        exp_t e;
        e.cyc = cyc; e.st = st; e.fl = fl; e.tr = tr; e.bk = bk; e.req = req;
        q.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr(logic a, logic t);
        cfg_wr = 1'b1; cfg_arm = a; cfg_trig = t;
        tick(1);
        cfg_wr = 1'b0; cfg_arm = 1'b0; cfg_trig = 1'b0;
    endtask

    // Monitor: compares scoreboard items when their cycle arrives.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cnt) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (seq_state !== e.st || status_flags !== e.fl ||
                trace_active !== e.tr || bkpt_req !== e.bk) begin
                failures++;
                $display("FAIL %s cyc=%0d actual st=%0d fl=%b tr=%b bk=%b expected st=%0d fl=%b tr=%b bk=%b",
                         e.req, cnt, seq_state, status_flags, trace_active, bkpt_req,
                         e.st, e.fl, e.tr, e.bk);
            end
        end
    end

    initial begin
        int c;
        tick(3);
        rst = 1'b0;
        // R1 reset state
        checks++;
        if (seq_state !== 3'd0 || status_flags !== 2'b00 || trace_active !== 1'b0 || bkpt_req !== 1'b0) begin
            failures++;
            $display("FAIL R1 actual st=%0d fl=%b tr=%b bk=%b expected st=0 fl=00 tr=0 bk=0",
                     seq_state, status_flags, trace_active, bkpt_req);
        end

        // R2/R12 arm
        c = cnt; expa(c + 1, 3'd1, 2'b00, 1'b1, 1'b0, "R2"); wr(1'b1, 1'b0);

        // R3/R4 forced match on ch0: S1 -> S2 after three edges
        c = cnt; fetch_match = 2'b01;
        expa(c + 3, 3'd1, 2'b00, 1'b1, 1'b0, "R3");
        expa(c + 4, 3'd2, 2'b01, 1'b1, 1'b0, "R3");
        tick(1); fetch_match = '0; tick(4);

        // R5 tagged ch1 ignores fetch match
        cfg_tag_mode = 2'b10;
        c = cnt; fetch_match = 2'b10;
        expa(c + 5, 3'd2, 2'b01, 1'b1, 1'b0, "R5");
        tick(1); fetch_match = '0; tick(5);

        // R4/R5 tag hit ch1 in S2 -> Final, then R13 hit in Final, R10 trace window
        c = cnt; tag_hit = 2'b10;
        expa(c + 1, 3'd4, 2'b11, 1'b1, 1'b0, "R4");
        tick(1); tag_hit = '0; tick(1);
        tag_hit = 2'b10;
        expa(c + 3, 3'd4, 2'b11, 1'b1, 1'b0, "R13");
        expa(c + 8, 3'd4, 2'b11, 1'b1, 1'b0, "R10");
        expa(c + 9, 3'd0, 2'b11, 1'b0, 1'b0, "R10");
        tick(1); tag_hit = '0; tick(7);

        // R13 hit while Disarmed
        c = cnt; tag_hit = 2'b10;
        expa(c + 1, 3'd0, 2'b11, 1'b0, 1'b0, "R13");
        tick(1); tag_hit = '0;

        // R9 trigger alone while Disarmed is ignored
        c = cnt; expa(c + 1, 3'd0, 2'b11, 1'b0, 1'b0, "R9"); wr(1'b0, 1'b1);

        // R9 arm+trigger together: immediate trigger, flags cleared
        c = cnt;
        expa(c + 1, 3'd4, 2'b00, 1'b1, 1'b0, "R9");
        expa(c + 9, 3'd0, 2'b00, 1'b0, 1'b0, "R10");
        wr(1'b1, 1'b1); tick(9);

        // R7 trigger and tag hit on the same edge
        c = cnt; expa(c + 1, 3'd1, 2'b00, 1'b1, 1'b0, "R2"); wr(1'b1, 1'b0);
        c = cnt; tag_hit = 2'b10;
        expa(c + 1, 3'd4, 2'b00, 1'b1, 1'b0, "R7");
        wr(1'b0, 1'b1); tag_hit = '0; tick(9);

        // R6 forced ch0 and tagged ch1 reach the same edge
        c = cnt; expa(c + 1, 3'd1, 2'b00, 1'b1, 1'b0, "R2"); wr(1'b1, 1'b0);
        c = cnt; fetch_match = 2'b01; tick(1); fetch_match = '0; tick(2);
        tag_hit = 2'b10;
        expa(c + 4, 3'd2, 2'b01, 1'b1, 1'b0, "R6");
        tick(1); tag_hit = '0; tick(1);

        // R11 end alignment: S2 ch1 -> Final with breakpoint, then Disarmed
        cfg_align_end = 1'b1; tick(1);
        c = cnt; tag_hit = 2'b10;
        expa(c + 1, 3'd4, 2'b11, 1'b0, 1'b1, "R11");
        expa(c + 2, 3'd0, 2'b11, 1'b0, 1'b0, "R11");
        tick(1); tag_hit = '0; tick(2);

        // R12/R8 end trigger
        c = cnt; expa(c + 1, 3'd1, 2'b00, 1'b1, 1'b0, "R12"); wr(1'b1, 1'b0);
        c = cnt;
        expa(c + 1, 3'd0, 2'b00, 1'b0, 1'b1, "R8");
        expa(c + 2, 3'd0, 2'b00, 1'b0, 1'b0, "R8");
        wr(1'b0, 1'b1); tick(2);

        // R2 disarm write from an armed state
        c = cnt; expa(c + 1, 3'd1, 2'b00, 1'b1, 1'b0, "R2"); wr(1'b1, 1'b0);
        c = cnt; expa(c + 1, 3'd0, 2'b00, 1'b0, 1'b0, "R2"); wr(1'b0, 1'b0);

        tick(3);
        if (q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard actual pending=%0d expected pending=0", q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule